// File: doc/BRIEF.md
# Colour Lookup Table with Byte-Wide Host Port

This block holds a 256-entry colour table. Each entry is an 18-bit word with three 6-bit components: red, green and blue. A host loads and inspects the table through four byte-wide registers selected by a 2-bit address. To load, the host writes a start entry into the write-index register and then streams bytes into the data register. A three-state component sequencer sends the first byte to red, the second to green and the third to blue. The entry is stored in one step when the blue byte arrives, and the index then moves on.

Reading works the same way but has its own index and its own sequencer. Each index register reads back its current position, so software can confirm how far a load got.

On the display side, every clock cycle an 8-bit pixel code is ANDed with a mask register and looked up. The three components appear on registered outputs one cycle later.

Top module: `palette_host_port`

Register map (`host_addr`): 0 = data, 1 = write index, 2 = read index, 3 = pixel mask.

## Requirements
- R1: Only data bits 5:0 of a byte written to the data register are kept. A data-register read returns the selected component in bits 5:0, with bits 7:6 equal to 0.
- R2: A write to the write-index register (address 1) loads the entry number and returns the write sequence to red. Reading address 1 returns the write index.
- R3: Data-register writes (address 0) fill red, then green, then blue. The entry changes only on the blue write, which stores all three components at once and advances the write index. The write index wraps from 255 to 0.
- R4: A write to the read-index register (address 2) sets the read entry. Data-register reads then return red, green and blue of that entry, and the read index advances after blue, wrapping from 255 to 0. Reading address 2 returns the read index.
- R5: After N complete triplets written from entry 0, reading address 1 returns N mod 256.
- R6: The pixel mask register (address 3) is readable and resets to 0xFF. The looked-up entry is `pix_idx & mask`.
- R7: The pixel outputs show the entry addressed by the pixel code one clock cycle after that code is presented.
- R8: If the host stores an entry in the same cycle that entry is looked up, the pixel outputs show the old contents in the following cycle and the new contents one cycle later.
- R9: A write to either index register returns both the write and the read sequences to red. Any red or green bytes already received are dropped and never stored.
- R10: After reset both indices are 0, both sequences are at red, the mask is 0xFF and the pixel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one access per cycle |
| host_rd | input | 1 | Host read strobe; ignored while host_wr is high |
| host_addr | input | 2 | Register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the cycle of the access |
| pix_idx | input | 8 | Pixel code to look up |
| pix_red | output | 6 | Red component of the looked-up entry |
| pix_green | output | 6 | Green component of the looked-up entry |
| pix_blue | output | 6 | Blue component of the looked-up entry |

## Verification
The bench stops a triplet part-way and then rewrites an index register. A design that stored on red or green, or that kept the dropped bytes, would leave a mixed entry that the read sequence exposes. It drives the write index past 255 and reads it back after 300 triplets, which catches a wide or saturating counter. It also presents the pixel code of an entry in the very cycle that entry is stored, which catches a write-through or a zero-latency lookup. With the mask narrowed to the low nibble, an unmasked index returns the wrong colour.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam int IDX_W  = 8;
    localparam int COMP_W = 6;
    localparam int BUS_W  = 8;
    localparam int DEPTH  = 1 << IDX_W;
    localparam int PAD_W  = BUS_W - COMP_W;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_WIDX = 2'd1,
        REG_RIDX = 2'd2,
        REG_MASK = 2'd3
    } reg_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] green;
        logic [COMP_W-1:0] blue;
    } rgb_t;

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

    function automatic logic [COMP_W-1:0] pick_comp(input rgb_t e, input phase_e p);
        case (p)
            PH_RED:   return e.red;
            PH_GREEN: return e.green;
            default:  return e.blue;
        endcase
    endfunction

endpackage

// File: rtl/palette_seq.sv
module palette_seq
    import palette_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_e           phase,
    output logic             last
);

    assign last = step && (phase == PH_BLUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx   <= '0;
            phase <= PH_RED;
        end else if (load) begin
            idx   <= load_val;
            phase <= PH_RED;
        end else if (clear) begin
            phase <= PH_RED;
        end else if (step) begin
            phase <= next_phase(phase);
            if (phase == PH_BLUE) begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/palette_store.sv
module palette_store
    import palette_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  rgb_t             wdata,
    input  logic [IDX_W-1:0] host_raddr,
    output rgb_t             host_rdata,
    input  logic [IDX_W-1:0] pix_addr,
    output rgb_t             pix_q
);

    rgb_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign host_rdata = mem[host_raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else begin
            pix_q <= mem[pix_addr];
        end
    end

endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
    import palette_pkg::*;
#(
    parameter logic [IDX_W-1:0] MASK_RESET = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [1:0]       host_addr,
    input  logic [BUS_W-1:0] host_wdata,
    output logic [BUS_W-1:0] host_rdata,
    input  logic [IDX_W-1:0] pix_idx,
    output logic [COMP_W-1:0] pix_red,
    output logic [COMP_W-1:0] pix_green,
    output logic [COMP_W-1:0] pix_blue
);

    reg_e reg_sel;
    assign reg_sel = reg_e'(host_addr);

    logic wr_data, wr_widx, wr_ridx, wr_mask, rd_data;
    assign wr_data = host_wr && (reg_sel == REG_DATA);
    assign wr_widx = host_wr && (reg_sel == REG_WIDX);
    assign wr_ridx = host_wr && (reg_sel == REG_RIDX);
    assign wr_mask = host_wr && (reg_sel == REG_MASK);
    assign rd_data = host_rd && !host_wr && (reg_sel == REG_DATA);

    logic [IDX_W-1:0] widx_q, ridx_q, mask_q;
    phase_e           wph_q, rph_q;
    logic             commit;
    logic             unused_rlast;

    palette_seq u_wseq (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_widx),
        .load_val (host_wdata[IDX_W-1:0]),
        .clear    (wr_ridx),
        .step     (wr_data),
        .idx      (widx_q),
        .phase    (wph_q),
        .last     (commit)
    );

    palette_seq u_rseq (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_ridx),
        .load_val (host_wdata[IDX_W-1:0]),
        .clear    (wr_widx),
        .step     (rd_data),
        .idx      (ridx_q),
        .phase    (rph_q),
        .last     (unused_rlast)
    );

    logic [COMP_W-1:0] shadow_red, shadow_green;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_red   <= '0;
            shadow_green <= '0;
        end else if (wr_data) begin
            if (wph_q == PH_RED)   shadow_red   <= host_wdata[COMP_W-1:0];
            if (wph_q == PH_GREEN) shadow_green <= host_wdata[COMP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= MASK_RESET;
        end else if (wr_mask) begin
            mask_q <= host_wdata[IDX_W-1:0];
        end
    end

    rgb_t entry_in, host_entry, pix_entry;
    assign entry_in = '{red: shadow_red, green: shadow_green, blue: host_wdata[COMP_W-1:0]};

    palette_store u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (commit),
        .waddr      (widx_q),
        .wdata      (entry_in),
        .host_raddr (ridx_q),
        .host_rdata (host_entry),
        .pix_addr   (pix_idx & mask_q),
        .pix_q      (pix_entry)
    );

    always_comb begin
        case (reg_sel)
            REG_DATA: host_rdata = {{PAD_W{1'b0}}, pick_comp(host_entry, rph_q)};
            REG_WIDX: host_rdata = widx_q;
            REG_RIDX: host_rdata = ridx_q;
            default:  host_rdata = mask_q;
        endcase
    end

    assign pix_red   = pix_entry.red;
    assign pix_green = pix_entry.green;
    assign pix_blue  = pix_entry.blue;

endmodule

// File: rtl/palette_host_port_chk.sv
module palette_host_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic       host_rd,
    input logic [1:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic [7:0] wr_idx,
    input logic [1:0] wr_ph,
    input logic [7:0] rd_idx,
    input logic [1:0] rd_ph
);

    AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_addr == 2'd0) |-> (host_rdata[7:6] == 2'b00)); // R1

    AST_WIDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd1) |=> (wr_idx == $past(host_wdata) && wr_ph == 2'd0)); // R2

    AST_WIDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd0 && wr_ph == 2'd2) |=> (wr_idx == $past(wr_idx) + 8'd1)); // R3

    AST_WIDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == 2'd0 && wr_ph != 2'd2) |=> (wr_idx == $past(wr_idx))); // R3

    AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (wr_ph != 2'd3 && rd_ph != 2'd3)); // R3

    AST_RIDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (host_rd && !host_wr && host_addr == 2'd0 && rd_ph == 2'd2) |=> (rd_idx == $past(rd_idx) + 8'd1)); // R4

    AST_INDEX_WRITE_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (host_wr && (host_addr == 2'd1 || host_addr == 2'd2)) |=> (wr_ph == 2'd0 && rd_ph == 2'd0)); // R9

endmodule

bind palette_host_port palette_host_port_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .wr_idx     (widx_q),
    .wr_ph      (wph_q),
    .rd_idx     (ridx_q),
    .rd_ph      (rph_q)
);

// File: tb/palette_host_port_tb_top.sv
module palette_host_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic [7:0] pix_idx = 8'd0;
    logic [5:0] pix_red, pix_green, pix_blue;

    always #2 clk = ~clk;

    palette_host_port dut_i (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit pix_on = 0;
    bit pix_force = 0;
    logic [7:0] pix_force_val = 8'd0;

    // behavioural reference state
    int m_r[256], m_g[256], m_b[256];
    int m_widx, m_wph, m_ridx, m_rph, m_mask, m_sr, m_sg;
    int exp_pr, exp_pg, exp_pb;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // pixel code stimulus
    always @(posedge clk) begin
        #1;
        if (pix_force) pix_idx = pix_force_val;
        else           pix_idx = pix_idx + 8'd37;
    end

    // cycle-by-cycle model, compared at the falling edge
    always @(negedge clk) begin
        int a, e_rd, pi, wd;
        a  = int'(host_addr);
        wd = int'(host_wdata);
        if (rst) begin
            m_widx = 0; m_wph = 0; m_ridx = 0; m_rph = 0; m_mask = 255;
            m_sr = 0; m_sg = 0; exp_pr = 0; exp_pg = 0; exp_pb = 0;
        end else begin
            if (pix_on)
                chk(pix_red === 6'(exp_pr) && pix_green === 6'(exp_pg) && pix_blue === 6'(exp_pb),
                    "R7 pixel lookup vs model",
                    int'({pix_red, pix_green, pix_blue}), (exp_pr << 12) | (exp_pg << 6) | exp_pb);
            case (a)
                0: e_rd = (m_rph == 0) ? m_r[m_ridx] : (m_rph == 1) ? m_g[m_ridx] : m_b[m_ridx];
                1: e_rd = m_widx;
                2: e_rd = m_ridx;
                default: e_rd = m_mask;
            endcase
            if (host_rd)
                chk(host_rdata === 8'(e_rd), (a == 0) ? "R4 data read vs model" : "R5 register read vs model",
                    int'(host_rdata), e_rd);
            pi = int'(pix_idx) & m_mask;
            exp_pr = m_r[pi]; exp_pg = m_g[pi]; exp_pb = m_b[pi];
            if (host_wr) begin
                case (a)
                    0: begin
                        if (m_wph == 0) begin m_sr = wd & 63; m_wph = 1; end
                        else if (m_wph == 1) begin m_sg = wd & 63; m_wph = 2; end
                        else begin
                            m_r[m_widx] = m_sr; m_g[m_widx] = m_sg; m_b[m_widx] = wd & 63;
                            m_widx = (m_widx + 1) % 256; m_wph = 0;
                        end
                    end
                    1: begin m_widx = wd; m_wph = 0; m_rph = 0; end
                    2: begin m_ridx = wd; m_wph = 0; m_rph = 0; end
                    default: m_mask = wd;
                endcase
            end else if (host_rd && a == 0) begin
                if (m_rph == 2) begin m_rph = 0; m_ridx = (m_ridx + 1) % 256; end
                else m_rph = m_rph + 1;
            end
        end
    end

    task automatic wr(input int addr, input int data);
        @(posedge clk); #1;
        host_wr = 1'b1; host_rd = 1'b0; host_addr = 2'(addr); host_wdata = 8'(data);
    endtask

    task automatic rd(input int addr, input int exp, input string tag);
        @(posedge clk); #1;
        host_wr = 1'b0; host_rd = 1'b1; host_addr = 2'(addr);
        @(negedge clk);
        chk(host_rdata === 8'(exp), tag, int'(host_rdata), exp);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic pix_look(input int code, input int er, input int eg, input int eb, input string tag);
        @(posedge clk);
        pix_force = 1'b1; pix_force_val = 8'(code);
        #1; host_wr = 1'b0; host_rd = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(pix_red == 6'(er) && pix_green == 6'(eg) && pix_blue == 6'(eb), tag,
            int'({pix_red, pix_green, pix_blue}), (er << 12) | (eg << 6) | eb);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pix_red == 6'd0 && pix_green == 6'd0 && pix_blue == 6'd0, "R10 pixel outputs zero in reset",
            int'({pix_red, pix_green, pix_blue}), 0);
        @(posedge clk); #1; rst = 1'b0;
        rd(3, 255, "R10 mask reset value");
        rd(1, 0, "R10 write index reset");
        rd(2, 0, "R10 read index reset");

        // full table load, upper bits set on purpose
        wr(1, 0);
        for (int i = 0; i < 256; i++) begin
            wr(0, i | 8'hC0);
            wr(0, (i * 3) & 255);
            wr(0, 255 - i);
        end
        rd(1, 0, "R3 write index wrapped 255 to 0");
        repeat (2) idle();
        pix_on = 1'b1;

        wr(2, 5);
        rd(0, 5, "R1 red bits 7:6 dropped");
        rd(0, 15, "R4 green of entry 5");
        rd(0, 250 & 63, "R4 blue of entry 5");
        rd(2, 6, "R4 read index advanced");
        wr(2, 255);
        rd(0, 255 & 63, "R4 red of entry 255");
        rd(0, (765) & 255 & 63, "R4 green of entry 255");
        rd(0, 0, "R4 blue of entry 255");
        rd(2, 0, "R4 read index wrapped");

        wr(1, 77);
        rd(1, 77, "R2 write index readback");

        // partial triplet then index rewrite
        wr(1, 10); wr(0, 1); wr(0, 2);
        wr(1, 10); wr(0, 7); wr(0, 8); wr(0, 9);
        wr(2, 10);
        rd(0, 7, "R9 red after discard");
        rd(0, 8, "R9 green after discard");
        rd(0, 9, "R9 blue after discard");
        wr(1, 20); wr(0, 33); wr(0, 34);
        wr(2, 20);
        rd(0, 20, "R3 red not stored before blue");
        rd(0, 60, "R3 green not stored before blue");
        rd(0, 235 & 63, "R3 blue unchanged");
        wr(2, 30);
        rd(0, 30, "R4 red of entry 30");
        wr(1, 30);
        rd(0, 30, "R9 read sequence back to red");

        // many triplets from zero
        wr(1, 0);
        for (int k = 0; k < 300; k++) begin
            wr(0, k); wr(0, k + 1); wr(0, k + 2);
        end
        rd(1, 44, "R5 index after 300 triplets");

        // mask
        wr(1, 3); wr(0, 11); wr(0, 22); wr(0, 33);
        wr(3, 8'h0F);
        rd(3, 15, "R6 mask readback");
        pix_look(8'hF3, 11, 22, 33, "R6 masked pixel lookup");
        wr(3, 8'hFF);
        pix_look(3, 11, 22, 33, "R7 one-cycle lookup");

        // same-cycle store and lookup
        wr(1, 40); wr(0, 1); wr(0, 2); wr(0, 3);
        wr(1, 40); wr(0, 4); wr(0, 5);
        @(posedge clk);
        pix_force = 1'b1; pix_force_val = 8'd40;
        #1; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'd6;
        @(posedge clk); #1; host_wr = 1'b0;
        @(negedge clk);
        chk(pix_red == 6'd1 && pix_green == 6'd2 && pix_blue == 6'd3, "R8 old entry on collision",
            int'({pix_red, pix_green, pix_blue}), (1 << 12) | (2 << 6) | 3);
        @(posedge clk); @(negedge clk);
        chk(pix_red == 6'd4 && pix_green == 6'd5 && pix_blue == 6'd6, "R8 new entry next cycle",
            int'({pix_red, pix_green, pix_blue}), (4 << 12) | (5 << 6) | 6);
        pix_force = 1'b0;
        repeat (20) idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule